// File: doc/BRIEF.md
# Execution Mode, Privilege and Stack Pointer Tracker

This block keeps the execution context of a small processor core. It records whether the core is running ordinary code (THREAD state) or servicing an exception (HANDLER state). It also holds two control bits that only apply in THREAD: one drops execution to unprivileged, the other switches from the main stack to the process stack. From this context it produces the effective privilege and the stack pointer currently in use.

The block holds the main and process stack pointers in separate registers. It serves word push and pop requests with a full-descending discipline. A push lowers the active pointer by one word and writes the item at the lowered address. A pop reads at the current address and then raises the pointer. Memory write and read strobes, the address and the write data are presented in the same cycle as the request. The memory itself and the read data path are outside the block.

The mode state machine has two states, THREAD and HANDLER. Its transitions are:
- ENTER: THREAD or HANDLER goes to HANDLER on an exception or supervisor-call strobe.
- LEAVE: HANDLER goes to THREAD on an exception-return strobe.
- HOLD: the state is kept in every other case.

A control-register write from unprivileged code is dropped and reported with a fault pulse.

Top module: `exec_state_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block enters THREAD with both control bits cleared. Both stack pointers load `sp_reset_val`. After reset `priv_eff`=1, `use_psp`=0, `sp_active`=`sp_reset_val` and `ctl_fault`=0.
- R2: `exc_enter` or `svc_call` high at an edge moves the block to HANDLER (`is_handler`=1) from the next cycle. `exc_return` high in HANDLER moves it to THREAD. Entry wins over a return in the same cycle. A return in THREAD is ignored.
- R3: In HANDLER, `priv_eff` is 1 whatever the privilege control bit holds.
- R4: In THREAD, `priv_eff` is the inverse of the privilege control bit. Control data bit 0 = 1 means unprivileged.
- R5: In HANDLER, `use_psp`=0 and `sp_active` shows the main stack pointer.
- R6: In THREAD, `use_psp` equals the stack control bit (control data bit 1, 1 = process stack). `sp_active` shows the pointer it selects.
- R7: `ctl_wr_en` with `priv_eff`=1 loads both control bits from `ctl_wr_data` at the edge. With `priv_eff`=0 the write is dropped, and `ctl_fault` is high for the following cycle only.
- R8: A lone `push_req` drives `mem_wr_en`=1, `mem_addr`=`sp_active`-4 and `mem_wdata`=`push_data` in the same cycle. The active pointer becomes `sp_active`-4 at the edge.
- R9: A lone `pop_req` drives `mem_rd_en`=1 and `mem_addr`=`sp_active` in the same cycle. The active pointer becomes `sp_active`+4 at the edge.
- R10: A push or pop changes only the active pointer. The other pointer keeps its value.
- R11: `push_req` and `pop_req` together are rejected. Both strobes stay low and neither pointer changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sp_reset_val | input | ADDR_W | Value loaded into both stack pointers at reset |
| exc_enter | input | 1 | Exception entry strobe |
| svc_call | input | 1 | Supervisor-call strobe, handled as an entry |
| exc_return | input | 1 | Exception return strobe |
| ctl_wr_en | input | 1 | Control register write request |
| ctl_wr_data | input | 2 | Bit 0 unprivileged, bit 1 process stack |
| push_req | input | 1 | Push one word |
| pop_req | input | 1 | Pop one word |
| push_data | input | DATA_W | Word to push |
| is_handler | output | 1 | 1 in HANDLER |
| priv_eff | output | 1 | Effective privilege |
| use_psp | output | 1 | Process stack is active |
| sp_active | output | ADDR_W | Active stack pointer |
| ctl_fault | output | 1 | Dropped control write pulse |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |

## Verification
The assertions assume `rst_n` is held low for at least one edge before any property is evaluated, so every stack pointer and control bit is defined. They also assume the strobes are stable around the clock edge, since the mode and pointer properties compare against the previous cycle. The stimulus asserts reset for several cycles at the start and changes all inputs only on the falling clock edge. Its random mix includes entry and return collisions, dropped writes and push/pop clashes, which the model accepts as legal inputs.

// File: rtl/exec_pkg.sv
package exec_pkg;

    typedef enum logic {
        MODE_THREAD  = 1'b0,
        MODE_HANDLER = 1'b1
    } mode_e;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_PUSH  = 2'd1,
        OP_POP   = 2'd2,
        OP_CLASH = 2'd3
    } stk_op_e;

    typedef struct packed {
        logic use_proc;
        logic unpriv;
    } ctl_t;

    localparam int CTL_W = 2;

endpackage

// File: rtl/exec_ctl_reg.sv
module exec_ctl_reg
    import exec_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    input  logic             priv_now,
    output ctl_t             ctl_q,
    output logic             fault_q
);

    ctl_t ctl_d;
    logic fault_d;

    always_comb begin
        ctl_d   = ctl_q;
        fault_d = 1'b0;
        if (wr_en) begin
            if (priv_now) begin
                ctl_d.unpriv   = wr_data[0];
                ctl_d.use_proc = wr_data[1];
            end else begin
                fault_d = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q   <= '0;
            fault_q <= 1'b0;
        end else begin
            ctl_q   <= ctl_d;
            fault_q <= fault_d;
        end
    end

    AST_DROP_UNPRIV_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !priv_now) |=> $stable(ctl_q)); // R7

    AST_FAULT_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !priv_now) |=> fault_q); // R7

    AST_NO_FAULT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> !fault_q); // R7

endmodule

// File: rtl/exec_mode_fsm.sv
module exec_mode_fsm
    import exec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic exc_enter,
    input  logic svc_call,
    input  logic exc_return,
    input  ctl_t ctl_q,
    output logic is_handler,
    output logic priv_eff,
    output logic use_psp
);

    mode_e mode_q;
    mode_e mode_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_THREAD;
        end else begin
            mode_q <= mode_d;
        end
    end

    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_THREAD: begin
                if (exc_enter || svc_call) begin
                    mode_d = MODE_HANDLER;
                end
            end
            MODE_HANDLER: begin
                if (exc_enter || svc_call) begin
                    mode_d = MODE_HANDLER;
                end else if (exc_return) begin
                    mode_d = MODE_THREAD;
                end
            end
            default: mode_d = MODE_THREAD;
        endcase
    end

    always_comb begin
        is_handler = 1'b0;
        priv_eff   = 1'b1;
        use_psp    = 1'b0;
        unique case (mode_q)
            MODE_THREAD: begin
                priv_eff = !ctl_q.unpriv;
                use_psp  = ctl_q.use_proc;
            end
            MODE_HANDLER: begin
                is_handler = 1'b1;
            end
            default: begin
                is_handler = 1'b0;
            end
        endcase
    end

    AST_ENTRY_TO_HANDLER: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_enter || svc_call) |=> is_handler); // R2

    AST_RETURN_TO_THREAD: assert property (@(posedge clk) disable iff (!rst_n)
        (is_handler && exc_return && !exc_enter && !svc_call) |=> !is_handler); // R2

    AST_THREAD_RETURN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_handler && !exc_enter && !svc_call) |=> !is_handler); // R2

endmodule

// File: rtl/exec_stack_bank.sv
module exec_stack_bank
    import exec_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int NUM_SP = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rst_val,
    input  logic              sel_proc,
    input  logic              push_req,
    input  logic              pop_req,
    input  logic [DATA_W-1:0] push_data,
    output logic [ADDR_W-1:0] sp_active,
    output logic              mem_wr_en,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);

    localparam int STEP_BYTES = DATA_W / 8;
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(STEP_BYTES);
    localparam int SEL_W = (NUM_SP > 1) ? $clog2(NUM_SP) : 1;

    logic [ADDR_W-1:0] sp_q [NUM_SP];
    logic [SEL_W-1:0]  sel;
    stk_op_e           op;

    assign sel = SEL_W'(sel_proc);

    always_comb begin
        unique case ({push_req, pop_req})
            2'b10:   op = OP_PUSH;
            2'b01:   op = OP_POP;
            2'b11:   op = OP_CLASH;
            default: op = OP_IDLE;
        endcase
    end

    for (genvar g = 0; g < NUM_SP; g++) begin : g_sp
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sp_q[g] <= rst_val;
            end else if (sel == SEL_W'(g)) begin
                unique case (op)
                    OP_PUSH: sp_q[g] <= sp_q[g] - STEP;
                    OP_POP:  sp_q[g] <= sp_q[g] + STEP;
                    default: sp_q[g] <= sp_q[g];
                endcase
            end
        end

        AST_IDLE_POINTER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (sel != SEL_W'(g)) |=> $stable(sp_q[g])); // R10

        AST_CLASH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (push_req && pop_req) |=> $stable(sp_q[g])); // R11
    end

    assign sp_active = sp_q[sel];

    always_comb begin
        mem_wr_en = 1'b0;
        mem_rd_en = 1'b0;
        mem_addr  = sp_active;
        mem_wdata = push_data;
        unique case (op)
            OP_PUSH: begin
                mem_wr_en = 1'b1;
                mem_addr  = sp_active - STEP;
            end
            OP_POP: begin
                mem_rd_en = 1'b1;
            end
            default: begin
                mem_wr_en = 1'b0;
            end
        endcase
    end

    AST_PUSH_DESCENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && !pop_req) |=> (sp_active == $past(sp_active) - STEP)
            || ($past(sel) != sel)); // R8

    AST_POP_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !push_req) |=> (sp_active == $past(sp_active) + STEP)
            || ($past(sel) != sel)); // R9

endmodule

// File: rtl/exec_state_unit.sv
module exec_state_unit
    import exec_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] sp_reset_val,
    input  logic              exc_enter,
    input  logic              svc_call,
    input  logic              exc_return,
    input  logic              ctl_wr_en,
    input  logic [1:0]        ctl_wr_data,
    input  logic              push_req,
    input  logic              pop_req,
    input  logic [DATA_W-1:0] push_data,
    output logic              is_handler,
    output logic              priv_eff,
    output logic              use_psp,
    output logic [ADDR_W-1:0] sp_active,
    output logic              ctl_fault,
    output logic              mem_wr_en,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);

    ctl_t ctl_q;

    exec_ctl_reg u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (ctl_wr_en),
        .wr_data  (ctl_wr_data),
        .priv_now (priv_eff),
        .ctl_q    (ctl_q),
        .fault_q  (ctl_fault)
    );

    exec_mode_fsm u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .exc_enter  (exc_enter),
        .svc_call   (svc_call),
        .exc_return (exc_return),
        .ctl_q      (ctl_q),
        .is_handler (is_handler),
        .priv_eff   (priv_eff),
        .use_psp    (use_psp)
    );

    exec_stack_bank #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .NUM_SP (2)
    ) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .rst_val   (sp_reset_val),
        .sel_proc  (use_psp),
        .push_req  (push_req),
        .pop_req   (pop_req),
        .push_data (push_data),
        .sp_active (sp_active),
        .mem_wr_en (mem_wr_en),
        .mem_rd_en (mem_rd_en),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    AST_HANDLER_PRIVILEGED: assert property (@(posedge clk) disable iff (!rst_n)
        is_handler |-> priv_eff); // R3

    AST_HANDLER_MAIN_STACK: assert property (@(posedge clk) disable iff (!rst_n)
        is_handler |-> !use_psp); // R5

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_wr_en && mem_rd_en)); // R11

endmodule

// File: tb/test_exec_state_unit.sv
`timescale 1ns/1ps
module test_exec_state_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] sp_reset_val;
    logic        exc_enter, svc_call, exc_return, ctl_wr_en, push_req, pop_req;
    logic [1:0]  ctl_wr_data;
    logic [31:0] push_data;
    logic        is_handler, priv_eff, use_psp, ctl_fault, mem_wr_en, mem_rd_en;
    logic [31:0] sp_active, mem_addr, mem_wdata;

    int checks = 0;
    int errors = 0;

    logic        m_hnd, m_np, m_ps, m_fault;
    logic [31:0] m_msp, m_psp;

    always #2.5 clk = ~clk;

    exec_state_unit i_exec_state_unit (
        .clk(clk), .rst_n(rst_n), .sp_reset_val(sp_reset_val),
        .exc_enter(exc_enter), .svc_call(svc_call), .exc_return(exc_return),
        .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
        .push_req(push_req), .pop_req(pop_req), .push_data(push_data),
        .is_handler(is_handler), .priv_eff(priv_eff), .use_psp(use_psp),
        .sp_active(sp_active), .ctl_fault(ctl_fault),
        .mem_wr_en(mem_wr_en), .mem_rd_en(mem_rd_en),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    function automatic logic f_priv();
        return m_hnd || !m_np;
    endfunction

    function automatic logic f_psp();
        return !m_hnd && m_ps;
    endfunction

    function automatic logic [31:0] f_sp();
        return f_psp() ? m_psp : m_msp;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive_idle();
        exc_enter = 0; svc_call = 0; exc_return = 0; ctl_wr_en = 0;
        ctl_wr_data = 0; push_req = 0; pop_req = 0; push_data = 0;
    endtask

    task automatic do_reset(input logic [31:0] rv);
        drive_idle();
        sp_reset_val = rv;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        m_hnd = 0; m_np = 0; m_ps = 0; m_fault = 0; m_msp = rv; m_psp = rv;
        #1;
        chk("R1 is_handler", 32'(is_handler), 0);
        chk("R1 priv_eff", 32'(priv_eff), 1);
        chk("R1 use_psp", 32'(use_psp), 0);
        chk("R1 sp_active", sp_active, rv);
        chk("R1 ctl_fault", 32'(ctl_fault), 0);
    endtask

    task automatic step(input logic e, input logic s, input logic r, input logic w,
                        input logic [1:0] wd, input logic pu, input logic po,
                        input logic [31:0] pd);
        logic p, ap, en, nh;
        logic [31:0] sp;
        exc_enter = e; svc_call = s; exc_return = r; ctl_wr_en = w;
        ctl_wr_data = wd; push_req = pu; pop_req = po; push_data = pd;
        #1;
        p = f_priv(); ap = f_psp(); sp = f_sp();
        chk("R2 is_handler", 32'(is_handler), 32'(m_hnd));
        chk(m_hnd ? "R3 priv_eff" : "R4 priv_eff", 32'(priv_eff), 32'(p));
        chk(m_hnd ? "R5 use_psp" : "R6 use_psp", 32'(use_psp), 32'(ap));
        chk(m_hnd ? "R5 sp_active" : "R6 sp_active", sp_active, sp);
        chk("R7 ctl_fault", 32'(ctl_fault), 32'(m_fault));
        chk((pu && po) ? "R11 mem_wr_en" : "R8 mem_wr_en", 32'(mem_wr_en), 32'(pu && !po));
        chk((pu && po) ? "R11 mem_rd_en" : "R9 mem_rd_en", 32'(mem_rd_en), 32'(po && !pu));
        if (pu && !po) begin
            chk("R8 mem_addr", mem_addr, sp - 32'd4);
            chk("R8 mem_wdata", mem_wdata, pd);
        end
        if (po && !pu) chk("R9 mem_addr", mem_addr, sp);
        @(posedge clk);
        m_fault = w && !p;
        if (w && p) begin m_np = wd[0]; m_ps = wd[1]; end
        en = e || s;
        nh = en ? 1'b1 : (r ? 1'b0 : m_hnd);
        m_hnd = nh;
        if (pu ^ po) begin
            if (ap) m_psp = pu ? m_psp - 32'd4 : m_psp + 32'd4;
            else    m_msp = pu ? m_msp - 32'd4 : m_msp + 32'd4;
        end
        @(negedge clk);
        drive_idle();
    endtask

    initial begin
        #400000;
        checks++;
        errors++;
        $display("FAIL watchdog all requirements actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        rst_n = 0;
        drive_idle();
        sp_reset_val = 0;
        @(negedge clk);
        do_reset(32'h2000_1000);

        // R10: process stack use, then observe the untouched main pointer
        step(0,0,0,1,2'b10,0,0,0);
        step(0,0,0,0,0,1,0,32'hAAAA_0001);
        step(0,0,0,0,0,1,0,32'hAAAA_0002);
        step(1,0,0,0,0,0,0,0);
        #1 chk("R10 main pointer held", sp_active, 32'h2000_1000);
        step(0,0,1,0,0,0,0,0);
        #1 chk("R10 process pointer kept", sp_active, 32'h2000_0FF8);
        // R7: become unprivileged, then a dropped write faults for one cycle
        step(0,0,0,1,2'b11,0,0,0);
        step(0,0,0,1,2'b00,0,0,0);
        #1 chk("R7 fault pulse", 32'(ctl_fault), 1);
        step(0,0,0,0,0,0,0,0);
        #1 chk("R7 fault one cycle", 32'(ctl_fault), 0);
        chk("R7 bits unchanged", 32'(priv_eff), 0);
        // R2: supervisor call enters handler; entry beats return
        step(0,1,0,0,0,0,0,0);
        step(1,0,1,0,0,0,0,0);
        #1 chk("R2 entry wins", 32'(is_handler), 1);
        step(0,0,1,0,0,0,0,0);
        step(0,0,1,0,0,0,0,0);
        #1 chk("R2 return in thread ignored", 32'(is_handler), 0);
        // R11: clash rejected
        step(0,0,0,0,0,1,1,32'h1234_5678);
        #1 chk("R11 pointer unchanged", sp_active, 32'h2000_0FF8);

        do_reset(32'h0001_0000);
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] rv;
            rv = $urandom;
            step(rv[2:0] == 0, rv[5:3] == 0, rv[8:6] < 2, rv[10:9] == 0,
                 rv[12:11], rv[14:13] == 0, rv[16:15] == 0, $urandom);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule